// File: doc/BRIEF.md
# Prescaled SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock through two cascaded dividers. A small prescaler with the divide values 2, 3, 5 and 7 produces a one-cycle enable tick. A scaler then counts those ticks and flips the clock level once a half period has elapsed. A double-rate input halves the scaler count. The serial clock output rests at the programmed polarity whenever the frame-enable input is low. During a frame the block raises one-cycle shift and sample strobes in the same cycle that the clock changes level. The phase setting decides which edge carries which strobe.

A combinational helper is also part of the block. Given a wanted divide ratio (system clock over serial clock), it returns the first prescaler/scaler code pair whose product reaches that ratio. It tries every scaler code for the smallest prescaler before it moves on to the next prescaler. When no pair is large enough, it returns the largest codes and raises a miss flag.

Top module: `spi_baud_gen`

## Requirements
- R1: The prescaler select code picks the prescale value P: code 0 gives 2, code 1 gives 3, code 2 gives 5 and code 3 gives 7.
- R2: The scaler select code picks the scale value S: codes 0 to 3 give 2, 4, 6 and 8, and each code k from 4 to 15 gives 2 to the power k (16 up to 32768).
- R3: With the double-rate input low, the clock level changes every P*(S/2) system cycles. The first change comes P*(S/2) rising edges after the first edge that samples the frame enable high.
- R4: With the double-rate input high, the half period is P*max(1, floor(S/4)) cycles. Scale value 2 therefore keeps its single-rate timing, and scale value 6 gives one tick.
- R5: While the frame enable is low, the serial clock equals the polarity input and both strobes stay low. Both counters restart from zero, so a frame that was dropped partway and is enabled again counts its first half period in full.
- R6: Each level change of the serial clock comes with exactly one strobe, one cycle wide, in the same cycle. The leading edge is the change away from the idle level. With phase 0, sample goes on leading edges and shift on trailing edges. Phase 1 swaps them.
- R7: The helper returns the first pair (prescaler code, scaler code) whose product P*S is at least the requested ratio. Prescaler codes are scanned from 0 to 3 in the outer order and scaler codes from 0 to 15 in the inner order.
- R8: When no pair reaches the requested ratio (above 7*32768), the helper returns prescaler code 3 and scaler code 15 with the miss flag high. Otherwise the miss flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Frame enable; counters run while high |
| pre_sel | input | 2 | Prescaler select code |
| scl_sel | input | 4 | Scaler select code |
| dbl | input | 1 | Double-rate select |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Phase: which edge carries the sample strobe |
| sck | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle strobe to shift out the next bit |
| sample_stb | output | 1 | One-cycle strobe to capture the incoming bit |
| req_div | input | 20 | Requested divide ratio for the helper |
| pick_pre | output | 2 | Helper result: prescaler code |
| pick_scl | output | 4 | Helper result: scaler code |
| pick_miss | output | 1 | Helper result: no pair reaches the ratio |

## Verification
The bench targets the odd prescale values and the non-linear part of the scale table. A divider that treats P as a power of two, or that treats the low scale codes as shifts, would place every edge in the wrong cycle. Double-rate mode is run with scale values 2 and 6. A design that lets the half count reach zero would hang or toggle every tick, and one that rounds 6/4 up would stretch the half period. A frame is dropped partway through a half period and then restarted, which exposes any counter that keeps its stale count. The helper is probed at ratio 6, where scanning the scaler first would give the wrong pair, and just past the largest product, where the miss flag has to rise.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

    localparam int PRE_SEL_W = 2;
    localparam int SCL_SEL_W = 4;
    localparam int PRE_CNT_W = 3;
    localparam int SCL_DIV_W = 16;
    localparam int HALF_W    = SCL_DIV_W - 1;
    localparam int PRE_CODES = 1 << PRE_SEL_W;
    localparam int SCL_CODES = 1 << SCL_SEL_W;

    typedef struct packed {
        logic lvl;
        logic shift;
        logic sample;
    } sck_state_t;

    // prescale value for a select code: 2, 3, 5, 7
    function automatic logic [PRE_CNT_W-1:0] pre_div(input logic [PRE_SEL_W-1:0] code);
        case (code)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            2'd2:    return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    // scale value: linear steps of two for low codes, powers of two above
    function automatic logic [SCL_DIV_W-1:0] scl_div(input logic [SCL_SEL_W-1:0] code);
        logic [SCL_DIV_W-1:0] v;
        if (code < 4'd4)
            v = ({{(SCL_DIV_W-SCL_SEL_W){1'b0}}, code} + 16'd1) << 1;
        else
            v = 16'd1 << code;
        return v;
    endfunction

    // prescaled ticks per half period of the serial clock
    function automatic logic [HALF_W-1:0] half_ticks(input logic [SCL_SEL_W-1:0] code,
                                                     input logic dbl);
        logic [SCL_DIV_W-1:0] s;
        logic [SCL_DIV_W-1:0] h;
        s = scl_div(code);
        h = dbl ? (s >> 2) : (s >> 1);
        if (h == '0)
            h = {{(SCL_DIV_W-1){1'b0}}, 1'b1};
        return h[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/spi_prescale_tick.sv
module spi_prescale_tick
    import spi_baud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [PRE_SEL_W-1:0] pre_sel,
    output logic                 tick
);

    logic [PRE_CNT_W-1:0] cnt_d, cnt_q;
    logic [PRE_CNT_W-1:0] last;

    always_comb begin
        last  = pre_div(pre_sel) - 1'b1;
        tick  = run && (cnt_q >= last);
        cnt_d = cnt_q;
        if (!run || tick)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/spi_half_count.sv
module spi_half_count
    import spi_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [HALF_W-1:0] half,
    output logic              flip
);

    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        flip  = tick && (cnt_q >= half - 1'b1);
        cnt_d = cnt_q;
        if (!run || flip)
            cnt_d = '0;
        else if (tick)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !flip) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/spi_rate_pick.sv
module spi_rate_pick
    import spi_baud_pkg::*;
#(
    parameter int RATIO_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RATIO_W-1:0]   req_div,
    output logic [PRE_SEL_W-1:0] pick_pre,
    output logic [SCL_SEL_W-1:0] pick_scl,
    output logic                 pick_miss
);

    localparam int PROD_W = 32;

    logic              found;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] chosen;

    always_comb begin
        found    = 1'b0;
        pick_pre = '1;
        pick_scl = '1;
        prod     = '0;
        chosen   = PROD_W'(pre_div('1)) * PROD_W'(scl_div('1));
        for (int i = 0; i < PRE_CODES; i++) begin
            for (int j = 0; j < SCL_CODES; j++) begin
                prod = PROD_W'(pre_div(PRE_SEL_W'(i))) * PROD_W'(scl_div(SCL_SEL_W'(j)));
                if (!found && (prod >= PROD_W'(req_div))) begin
                    found    = 1'b1;
                    pick_pre = PRE_SEL_W'(i);
                    pick_scl = SCL_SEL_W'(j);
                    chosen   = prod;
                end
            end
        end
        pick_miss = !found;
    end

    always_ff @(posedge clk) begin
        if (rst_n && !pick_miss)
            assert_pick_reaches_R7: assert (chosen >= PROD_W'(req_div));
        if (rst_n && pick_miss)
            assert_miss_codes_R8: assert (pick_pre == '1 && pick_scl == '1);
    end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_baud_pkg::*;
#(
    parameter int RATIO_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [PRE_SEL_W-1:0] pre_sel,
    input  logic [SCL_SEL_W-1:0] scl_sel,
    input  logic                 dbl,
    input  logic                 cpol,
    input  logic                 cpha,
    output logic                 sck,
    output logic                 shift_stb,
    output logic                 sample_stb,
    input  logic [RATIO_W-1:0]   req_div,
    output logic [PRE_SEL_W-1:0] pick_pre,
    output logic [SCL_SEL_W-1:0] pick_scl,
    output logic                 pick_miss
);

    logic              tick;
    logic              flip;
    logic              lead;
    logic [HALF_W-1:0] half;
    sck_state_t        st_d, st_q;

    assign half = half_ticks(scl_sel, dbl);

    spi_prescale_tick u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pre_sel (pre_sel),
        .tick    (tick)
    );

    spi_half_count u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .half  (half),
        .flip  (flip)
    );

    spi_rate_pick #(.RATIO_W(RATIO_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_div   (req_div),
        .pick_pre  (pick_pre),
        .pick_scl  (pick_scl),
        .pick_miss (pick_miss)
    );

    always_comb begin
        st_d        = st_q;
        st_d.shift  = 1'b0;
        st_d.sample = 1'b0;
        lead        = ~st_q.lvl;
        if (!run) begin
            st_d.lvl = 1'b0;
        end else if (flip) begin
            st_d.lvl    = ~st_q.lvl;
            st_d.shift  = cpha ? lead : ~lead;
            st_d.sample = cpha ? ~lead : lead;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sck        = cpol ^ st_q.lvl;
    assign shift_stb  = st_q.shift;
    assign sample_stb = st_q.sample;

    assert_strobe_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb || sample_stb) |-> (st_q.lvl != $past(st_q.lvl)));

    assert_change_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (st_q.lvl != $past(st_q.lvl))) |-> $onehot({shift_stb, sample_stb}));

    assert_lead_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !$past(cpha)) |-> st_q.lvl);

    assert_idle_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!st_q.lvl && !shift_stb && !sample_stb));

endmodule

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  pre_sel = '0;
    logic [3:0]  scl_sel = '0;
    logic        dbl = 1'b0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        sck, shift_stb, sample_stb;
    logic [19:0] req_div = '0;
    logic [1:0]  pick_pre;
    logic [3:0]  pick_scl;
    logic        pick_miss;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int    cyc;
        bit    sck;
        bit    sh;
        bit    sa;
        string tag;
    } ev_t;
    ev_t exp_q[$];
    bit  idle_pending = 0;

    always #4 clk = ~clk;

    spi_baud_gen u_spi_baud_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .scl_sel(scl_sel),
        .dbl(dbl), .cpol(cpol), .cpha(cpha), .sck(sck), .shift_stb(shift_stb),
        .sample_stb(sample_stb), .req_div(req_div), .pick_pre(pick_pre),
        .pick_scl(pick_scl), .pick_miss(pick_miss)
    );

    function automatic int pval(int c);
        case (c)
            0: return 2;
            1: return 3;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int sval(int c);
        if (c < 4) return 2 * (c + 1);
        return 1 << c;
    endfunction

    function automatic int hval(int c, bit d);
        int h;
        h = d ? sval(c) / 4 : sval(c) / 2;
        return (h == 0) ? 1 : h;
    endfunction

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // monitor: pops expected edges as the design produces them
    int  c = 0;
    bit  prev_sck = 0;
    always begin
        bit r;
        @(posedge clk);
        r = run;
        #1;
        if (rst_n) begin
            if (r) begin
                c++;
                if (sck !== prev_sck || shift_stb || sample_stb) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R3 unexpected edge", $sformatf("cyc=%0d", c), "none");
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        check(e.cyc == c && sck == e.sck && shift_stb == e.sh && sample_stb == e.sa,
                              e.tag,
                              $sformatf("cyc=%0d sck=%b sh=%b sa=%b", c, sck, shift_stb, sample_stb),
                              $sformatf("cyc=%0d sck=%b sh=%b sa=%b", e.cyc, e.sck, e.sh, e.sa));
                    end
                end
            end else begin
                c = 0;
                if (idle_pending) begin
                    idle_pending = 0;
                    check(sck == cpol && !shift_stb && !sample_stb, "R5 idle rest",
                          $sformatf("sck=%b sh=%b sa=%b", sck, shift_stb, sample_stb),
                          $sformatf("sck=%b sh=0 sa=0", cpol));
                end
            end
        end
        prev_sck = sck;
    end

    // driver: pushes the expected edges then runs the frame
    task automatic run_frame(input int pc, input int sc, input bit db, input bit cp,
                             input bit ph, input int n, input int extra, input string tag);
        int hp;
        hp = pval(pc) * hval(sc, db);
        @(negedge clk);
        pre_sel = 2'(pc); scl_sel = 4'(sc); dbl = db; cpol = cp; cpha = ph;
        @(negedge clk);
        for (int j = 1; j <= n; j++) begin
            ev_t e;
            bit  ld;
            ld    = (j % 2) == 1;
            e.cyc = j * hp;
            e.sck = cp ^ ld;
            e.sh  = ph ? ld : !ld;
            e.sa  = ph ? !ld : ld;
            e.tag = tag;
            exp_q.push_back(e);
        end
        run = 1'b1;
        repeat (n * hp + extra) @(negedge clk);
        run = 1'b0;
        idle_pending = 1;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all edges seen"},
              $sformatf("left=%0d", exp_q.size()), "left=0");
        exp_q.delete();
    endtask

    task automatic pick_chk(input int rq, input int ep, input int es, input bit em, input string tag);
        @(negedge clk);
        req_div = 20'(rq);
        #1;
        check(pick_pre == 2'(ep) && pick_scl == 4'(es) && pick_miss == em, tag,
              $sformatf("pre=%0d scl=%0d miss=%b", pick_pre, pick_scl, pick_miss),
              $sformatf("pre=%0d scl=%0d miss=%b", ep, es, em));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck == 1'b0 && !shift_stb && !sample_stb, "R5 reset state",
              $sformatf("sck=%b sh=%b sa=%b", sck, shift_stb, sample_stb), "sck=0 sh=0 sa=0");

        run_frame(0, 0, 0, 0, 0, 6, 0, "R1 R3 R6 P2 S2");
        run_frame(1, 2, 0, 1, 1, 4, 0, "R1 R2 R6 P3 S6 cpol1 cpha1");
        run_frame(2, 3, 1, 0, 1, 4, 0, "R4 P5 S8 double");
        run_frame(3, 0, 1, 1, 0, 4, 0, "R4 P7 S2 double saturates");
        run_frame(1, 2, 1, 0, 0, 4, 0, "R4 P3 S6 double rounds down");
        run_frame(2, 9, 0, 1, 0, 2, 0, "R2 R3 P5 S512");
        run_frame(3, 4, 0, 0, 1, 3, 20, "R5 P7 S16 dropped partway");
        run_frame(3, 4, 0, 0, 1, 2, 0, "R5 P7 S16 restart counts in full");
        run_frame(0, 15, 1, 0, 0, 2, 0, "R2 R4 P2 S32768 double");

        pick_chk(0, 0, 0, 0, "R7 ratio 0");
        pick_chk(4, 0, 0, 0, "R7 ratio 4");
        pick_chk(5, 0, 1, 0, "R7 ratio 5");
        pick_chk(6, 0, 1, 0, "R7 ratio 6 prescaler outer");
        pick_chk(65537, 1, 15, 0, "R7 ratio 65537");
        pick_chk(229376, 3, 15, 0, "R8 largest product fits");
        pick_chk(229377, 3, 15, 1, "R8 ratio beyond range");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule